// File: doc/BRIEF.md
# Audio Receive FIFO Read Formatter

This block holds samples from an audio serial receiver until a processor reads them. The receiver side pushes one deserialised sample per push. Each sample arrives MSB-aligned in a 32-bit field and carries a tag that marks it as a left or a right sample. A read strobe on the processor side returns one 32-bit word. That word holds either one sample or a packed left/right pair, depending on the active read mode.

The block also produces a fill level. In mono mode each sample counts double, so software sees a level that has the same meaning in every mode. Two kinds of read are flagged as errors: a read that finds too few samples, and a stereo read that breaks the left-then-right order. A push that arrives while the buffer is at capacity is dropped, and a separate pulse reports the drop.

Top module: `arx_fifo_fmt`

## Requirements
- R1: After reset, `level` is 0, `rd_data` is 0, `rd_err` is 0 and `ovf` is 0. The active mode is stereo and the expected channel is left.
- R2: In stereo mode (`cfg_mode` 2'b00), each accepted read removes one sample. It returns that sample's 32-bit value unchanged.
- R3: In packed-16 mode (2'b01), a read removes two samples. Call the older one A and the newer one B. The read returns {B[31:16], A[31:16]}.
- R4: In packed-8 mode (2'b10), a read removes two samples A (older) and B (newer). It returns {16'h0000, B[31:24], A[31:24]}.
- R5: In mono mode (2'b11), each accepted read removes one sample and returns its 32-bit value unchanged. The channel tag is ignored.
- R6: In the stereo and packed modes, `level` equals the number of stored samples, up to 16.
- R7: In mono mode, `level` equals twice the number of stored samples. Capacity is therefore 8 samples, and four mono samples give a level of 8.
- R8: A read that finds fewer samples than the mode needs has these effects: `rd_err` is 1 and `rd_data` is 0, and nothing is removed. The mode needs one sample in stereo and mono, and two in the packed modes.
- R9: A stereo read whose head sample's tag (`wr_right` at push, 0 = left, 1 = right) differs from the expected channel raises `rd_err`, and the sample is still returned and removed. After every stereo read, the expected channel becomes the opposite of the tag just read.
- R10: `cfg_mode` is taken into the active mode only at clock edges where the buffer is empty. A change of active mode resets the expected channel to left. While samples are stored, a new `cfg_mode` leaves `level` and the read format unchanged.
- R11: A push while the buffer is at capacity (16 samples, or 8 in mono) is dropped, even when a read occurs in the same cycle. `ovf` is 1 for exactly the cycle after that push.
- R12: `rd_data` and `rd_err` are registered and appear the cycle after `rd_en`. `rd_err` is 0 after a cycle without a read, and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Requested read mode: 00 stereo, 01 packed-16, 10 packed-8, 11 mono |
| wr_en | input | 1 | Push one sample |
| wr_right | input | 1 | Channel tag of the pushed sample, 1 = right |
| wr_sample | input | 32 | MSB-aligned sample value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Formatted read word |
| rd_err | output | 1 | Read error for the previous strobe |
| level | output | 5 | Fill level in half-pair units, 0 to 16 |
| ovf | output | 1 | Pulse: the previous push was dropped |

## Verification
Faults in the pointer or the count show up at `level` on the cycle after the push or read that caused them. A pointer fault also shows in the first later read word, which then does not match the bench's queue. A stuck or mistimed channel tracker cannot be seen until the next stereo read: `rd_err` is then wrong on the cycle after that strobe. A mode register that loads while samples are stored shows up the same cycle as a doubled or halved `level`, and at the next read as a wrongly packed word.

// File: rtl/arx_pkg.sv
package arx_pkg;

  localparam int unsigned SAMPLE_W = 32;

  typedef enum logic [1:0] {
    MODE_STEREO = 2'b00,
    MODE_PACK16 = 2'b01,
    MODE_PACK8  = 2'b10,
    MODE_MONO   = 2'b11
  } rd_mode_e;

  typedef struct packed {
    logic                is_right;
    logic [SAMPLE_W-1:0] data;
  } slot_t;

  // samples a single read consumes in a mode
  function automatic int unsigned pops_needed(rd_mode_e m);
    return (m == MODE_PACK16 || m == MODE_PACK8) ? 2 : 1;
  endfunction

  // number of samples the buffer may hold in a mode
  function automatic int unsigned capacity_of(rd_mode_e m, int unsigned depth);
    return (m == MODE_MONO) ? depth / 2 : depth;
  endfunction

  // reported level for a stored sample count
  function automatic int unsigned level_of(rd_mode_e m, int unsigned cnt);
    return (m == MODE_MONO) ? 2 * cnt : cnt;
  endfunction

  // read word: a is the older sample, b the newer one
  function automatic logic [SAMPLE_W-1:0] pack_word(rd_mode_e m,
                                                    logic [SAMPLE_W-1:0] a,
                                                    logic [SAMPLE_W-1:0] b);
    logic [SAMPLE_W-1:0] w;
    case (m)
      MODE_PACK16: w = {b[SAMPLE_W-1 -: 16], a[SAMPLE_W-1 -: 16]};
      MODE_PACK8:  w = {16'h0000, b[SAMPLE_W-1 -: 8], a[SAMPLE_W-1 -: 8]};
      default:     w = a;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/arx_slot_store.sv
module arx_slot_store
  import arx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_take,
  input  slot_t               wr_slot,
  input  logic [1:0]          pop_n,
  output slot_t               head0,
  output logic [SAMPLE_W-1:0] head1_data,
  output logic [CW-1:0]       count
);

  slot_t         mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr_nxt1;

  function automatic logic [AW-1:0] ptr_add(logic [AW-1:0] p, int unsigned k);
    int unsigned s;
    s = 32'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  assign rd_ptr_nxt1 = ptr_add(rd_ptr, 1);
  assign head0       = mem[rd_ptr];
  assign head1_data  = mem[rd_ptr_nxt1].data;

  always_ff @(posedge clk) begin
    if (wr_take) mem[wr_ptr] <= wr_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_take) wr_ptr <= ptr_add(wr_ptr, 1);
      rd_ptr <= ptr_add(rd_ptr, 32'(pop_n));
      count  <= count + CW'(wr_take) - CW'(pop_n);
    end
  end

  AST_POP_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);  // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);  // R6

endmodule

// File: rtl/arx_lr_phase.sv
module arx_lr_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic adv,
  input  logic seen_right,
  output logic expect_right
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      expect_right <= 1'b0;
    else if (flush)  expect_right <= 1'b0;
    else if (adv)    expect_right <= !seen_right;
  end

  AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !flush) |=> $stable(expect_right));  // R9

endmodule

// File: rtl/arx_rd_port.sv
module arx_rd_port
  import arx_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  rd_mode_e            mode,
  input  logic [CW-1:0]       count,
  input  slot_t               head0,
  input  logic [SAMPLE_W-1:0] head1_data,
  input  logic                expect_right,
  output logic [1:0]          pop_n,
  output logic                phase_adv,
  output logic                seen_right,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_err
);

  logic short_rd;
  logic order_bad;
  logic good_rd;

  assign short_rd   = 32'(count) < pops_needed(mode);
  assign good_rd    = rd_en && !short_rd;
  assign pop_n      = good_rd ? 2'(pops_needed(mode)) : 2'd0;
  assign phase_adv  = good_rd && (mode == MODE_STEREO);
  assign seen_right = head0.is_right;
  assign order_bad  = phase_adv && (head0.is_right != expect_right);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else if (rd_en) begin
      rd_data <= short_rd ? '0 : pack_word(mode, head0.data, head1_data);
      rd_err  <= short_rd || order_bad;
    end else begin
      rd_err  <= 1'b0;
    end
  end

  AST_SHORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && short_rd) |=> (rd_err && rd_data == '0));  // R8
  AST_NO_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_err);  // R12

endmodule

// File: rtl/arx_fifo_fmt.sv
module arx_fifo_fmt
  import arx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic                wr_en,
  input  logic                wr_right,
  input  logic [SAMPLE_W-1:0] wr_sample,
  input  logic                rd_en,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic                rd_err,
  output logic [CW-1:0]       level,
  output logic                ovf
);

  rd_mode_e            mode_q;
  logic [CW-1:0]       count;
  slot_t               head0;
  logic [SAMPLE_W-1:0] head1_data;
  logic [1:0]          pop_n;
  logic                phase_adv;
  logic                seen_right;
  logic                expect_right;
  logic                full;
  logic                wr_take;
  logic                mode_load;
  logic                mode_change;
  slot_t               wr_slot;

  assign full        = 32'(count) >= capacity_of(mode_q, DEPTH);
  assign wr_take     = wr_en && !full;
  assign mode_load   = (count == '0);
  assign mode_change = mode_load && (rd_mode_e'(cfg_mode) != mode_q);
  assign wr_slot     = '{is_right: wr_right, data: wr_sample};
  assign level       = CW'(level_of(mode_q, 32'(count)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STEREO;
      ovf    <= 1'b0;
    end else begin
      if (mode_load) mode_q <= rd_mode_e'(cfg_mode);
      ovf <= wr_en && full;
    end
  end

  arx_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_take    (wr_take),
    .wr_slot    (wr_slot),
    .pop_n      (pop_n),
    .head0      (head0),
    .head1_data (head1_data),
    .count      (count)
  );

  arx_lr_phase u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (mode_change),
    .adv          (phase_adv),
    .seen_right   (seen_right),
    .expect_right (expect_right)
  );

  arx_rd_port #(.CW(CW)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .mode         (mode_q),
    .count        (count),
    .head0        (head0),
    .head1_data   (head1_data),
    .expect_right (expect_right),
    .pop_n        (pop_n),
    .phase_adv    (phase_adv),
    .seen_right   (seen_right),
    .rd_data      (rd_data),
    .rd_err       (rd_err)
  );

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);  // R6
  AST_MONO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MONO) |-> !level[0]);  // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |=> $stable(mode_q));  // R10
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && pop_n == 2'd0) |=> (count == $past(count)));  // R11

endmodule

// File: tb/arx_fifo_fmt_tb.sv
module arx_fifo_fmt_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        wr_en = 1'b0;
  logic        wr_right = 1'b0;
  logic [31:0] wr_sample = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_err;
  logic [4:0]  level;
  logic        ovf;

  int n_tests = 0;
  int n_fail  = 0;

  logic [32:0] q[$];
  logic [1:0]  m_mode  = 2'b00;
  bit          m_phase = 1'b0;
  bit          lr_tog  = 1'b0;

  always #2 clk = ~clk;

  arx_fifo_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
    .wr_right(wr_right), .wr_sample(wr_sample), .rd_en(rd_en),
    .rd_data(rd_data), .rd_err(rd_err), .level(level), .ovf(ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(logic [1:0] m, logic [31:0] a, logic [31:0] b);
    if (m == 2'b01) return {b[31:24], b[23:16], a[31:24], a[23:16]};
    if (m == 2'b10) return {16'h0, b[31:24], a[31:24]};
    return a;
  endfunction

  function automatic string word_req(logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one clock cycle: drive, predict, check
  task automatic step(bit push, bit right, logic [31:0] smp, bit rd, logic [1:0] cfg);
    int          cnt;
    int          need;
    int          cap;
    bit          e_err;
    bit          e_ovf;
    logic [31:0] e_data;
    string       tag;
    logic [32:0] a;
    logic [32:0] b;
    @(negedge clk);
    wr_en = push; wr_right = right; wr_sample = smp; rd_en = rd; cfg_mode = cfg;
    cnt    = q.size();
    need   = (m_mode == 2'b01 || m_mode == 2'b10) ? 2 : 1;
    cap    = (m_mode == 2'b11) ? 8 : 16;
    e_err  = 1'b0;
    e_data = '0;
    tag    = "R12";
    if (rd) begin
      if (cnt < need) begin
        e_err = 1'b1; tag = "R8";
      end else begin
        a = q.pop_front();
        b = (need == 2) ? q.pop_front() : 33'h0;
        e_data = exp_word(m_mode, a[31:0], b[31:0]);
        tag = word_req(m_mode);
        if (m_mode == 2'b00) begin
          if (a[32] != m_phase) begin e_err = 1'b1; tag = "R9"; end
          m_phase = !a[32];
        end
      end
    end
    e_ovf = push && (cnt >= cap);
    if (push && !e_ovf) q.push_back({right, smp});
    if (cnt == 0) begin
      if (cfg != m_mode) m_phase = 1'b0;
      m_mode = cfg;
    end
    @(posedge clk);
    #1;
    if (rd) chk(tag, rd_data, e_data);
    chk(rd ? (e_err ? tag : "R9") : "R12", {31'b0, rd_err}, {31'b0, e_err});
    chk("R11", {31'b0, ovf}, {31'b0, e_ovf});
    chk(m_mode == 2'b11 ? "R7" : "R6", {27'b0, level},
        (m_mode == 2'b11) ? 32'(2 * q.size()) : 32'(q.size()));
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic drain(logic [1:0] cfg);
    while (q.size() != 0) step(1'b0, 1'b0, '0, 1'b1, cfg);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_a11c));
    #9 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", {27'b0, level}, 32'd0);
    chk("R1", rd_data, 32'd0);
    chk("R1", {31'b0, rd_err}, 32'd0);
    chk("R1", {31'b0, ovf}, 32'd0);

    // R8: empty read
    step(1'b0, 1'b0, '0, 1'b1, 2'b00);
    // R2: ordered stereo pairs
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 32'h1000_0000 + i, 1'b0, 2'b00);
      step(1'b1, 1'b1, 32'h2000_0000 + i, 1'b0, 2'b00);
    end
    drain(2'b00);
    // R9: right before left
    step(1'b1, 1'b1, 32'hCAFE_0001, 1'b0, 2'b00);
    step(1'b1, 1'b0, 32'hCAFE_0002, 1'b0, 2'b00);
    drain(2'b00);
    // R11: fill to 16, push more with a read in the same cycle
    for (int i = 0; i < 16; i++) step(1'b1, i[0], 32'hA000_0000 + i, 1'b0, 2'b00);
    chk("R6", {27'b0, level}, 32'd16);
    step(1'b1, 1'b0, 32'hDEAD_DEAD, 1'b1, 2'b00);
    step(1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, 2'b00);
    // R10: mode request ignored while not empty
    step(1'b0, 1'b0, '0, 1'b0, 2'b11);
    chk("R10", {27'b0, level}, 32'd16);
    drain(2'b11);
    step(1'b0, 1'b0, '0, 1'b0, 2'b11);
    // R7: four mono samples give level 8, capacity 8
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 32'h5500_0000 + i, 1'b0, 2'b11);
    chk("R7", {27'b0, level}, 32'd8);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'h6600_0000 + i, 1'b0, 2'b11);
    drain(2'b11);
    // R3: packed-16
    step(1'b0, 1'b0, '0, 1'b0, 2'b01);
    step(1'b1, 1'b0, 32'hAAAA_1111, 1'b0, 2'b01);
    step(1'b1, 1'b1, 32'hBBBB_2222, 1'b0, 2'b01);
    step(1'b0, 1'b0, '0, 1'b1, 2'b01);
    chk("R3", rd_data, 32'hBBBB_AAAA);
    // R8: single sample is a short read in packed mode
    step(1'b1, 1'b0, 32'h7700_0000, 1'b0, 2'b01);
    step(1'b0, 1'b0, '0, 1'b1, 2'b01);
    step(1'b1, 1'b1, 32'h8800_0000, 1'b0, 2'b01);
    step(1'b0, 1'b0, '0, 1'b1, 2'b01);
    // R4: packed-8
    step(1'b0, 1'b0, '0, 1'b0, 2'b10);
    step(1'b1, 1'b0, 32'h12FF_FFFF, 1'b0, 2'b10);
    step(1'b1, 1'b1, 32'h34FF_FFFF, 1'b0, 2'b10);
    step(1'b0, 1'b0, '0, 1'b1, 2'b10);
    chk("R4", rd_data, 32'h0000_3412);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit          p;
      bit          r;
      bit          ch;
      logic [1:0]  c;
      p  = ($urandom % 100) < 55;
      r  = ($urandom % 100) < 45;
      ch = lr_tog;
      if (($urandom % 100) < 10) ch = !ch;
      if (p) lr_tog = !ch;
      c = (($urandom % 100) < 4) ? 2'($urandom) : m_mode;
      if (($urandom % 100) < 2) c = 2'($urandom);
      step(p, ch, $urandom, r, c);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule